// File: doc/BRIEF.md
# Two-Port Byte Memory with Ownership Flags

This block is a synchronous two-port memory of 4096 bytes. A left port and a right port each have their own chip enable, flag select, write strobe, output enable, 12-bit address and 8-bit data path. Either port can read or write any byte on any cycle without waiting for the other side. Writes land at the clock edge. Read data is registered and appears one cycle after the request, then holds until the same port reads again.

Beside the array sits a bank of eight hardware ownership flags. Software on the two sides uses these flags to agree on who may touch a shared region. A port claims a flag by writing 0 to it and gives it back by writing 1. A claim on a flag that the other side holds is queued. When the holder gives the flag back, the queued side becomes the owner on the same edge. If both sides claim a free flag on the same cycle, the left side wins. A flag read only takes a new sample on the first cycle of a read. A read that is held on from the previous cycle keeps its old value, so a port must pulse its output enable or its flag select to see a change.

Top module: `dpram_sem_top`

## Requirements
- R1: With chip enable low and flag select high, a port is in array mode. A low write strobe stores the data byte at the address on that edge. A high write strobe with a low output enable reads: the byte is shown on the read data output after the edge. On any cycle with no read, the read data output keeps its last value.
- R2: The two ports work independently. A write on one port and a read of a different address on the other port in the same cycle both complete correctly.
- R3: If both ports write the same address in the same cycle, the left port's byte is stored.
- R4: A read in the same cycle as a write to the same address returns the byte held before that write.
- R5: A port is in standby when its chip enable and its flag select are both high. In standby it makes no access, and its standby output reads 1 one cycle later. With chip enable low, the standby output reads 0 one cycle later. With both chip enable and flag select low, the port makes no access to either the array or the flags.
- R6: With chip enable high and flag select low, a port is in flag mode. The address bits [2:0] select one of eight flags, and data bit 0 carries the written value: 0 claims the flag and 1 gives it back. Each flag is independent of the others.
- R7: A flag read returns 8'h00 when the reading port owns the flag, and 8'hFF otherwise.
- R8: A flag is never owned by both sides at once. A claim on a flag held by the other side leaves the owner unchanged and queues the claim. When a port that does not own a flag writes 1 to it, the port's own queued claim is cancelled.
- R9: When the owner writes 1 to a flag on which the other side has a queued claim, the other side becomes the owner on that same edge.
- R10: If both ports claim the same free flag in the same cycle, the left port becomes the owner and the right claim is queued.
- R11: A flag read takes a new sample only on the first cycle of a read. A read held on from the previous cycle keeps its earlier value. A new sample needs a cycle with output enable or flag select high in between.
- R12: After reset, both read data outputs are 8'h00, both standby outputs are 1, and all flags are free with nothing queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_cs_n | input | 1 | Left chip enable (array), active low |
| l_sel_n | input | 1 | Left flag select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 12 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, registered |
| l_standby | output | 1 | Left standby status, registered |
| r_cs_n | input | 1 | Right chip enable (array), active low |
| r_sel_n | input | 1 | Right flag select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 12 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, registered |
| r_standby | output | 1 | Right standby status, registered |

## Verification
The assertions assume that every control input has a defined level on each clock edge. They also assume that a port in flag mode only changes its address while it is not reading, so that a held read keeps the same flag. The stimulus meets both assumptions. It drives every input at the falling edge and puts each port in standby between operations. Before every flag read it inserts a standby cycle on that port, so each intended sample is a fresh read. The one held read is deliberate, and it is kept on a single flag.

// File: rtl/dpram_sem_pkg.sv
package dpram_sem_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_MEM  = 2'd1,
    ACC_SEM  = 2'd2,
    ACC_BAD  = 2'd3
  } acc_e;

  // Active-low chip enable and flag select pick the access target.
  function automatic acc_e acc_decode(input logic cs_n, input logic sel_n);
    case ({cs_n, sel_n})
      2'b01:   return ACC_MEM;
      2'b10:   return ACC_SEM;
      2'b11:   return ACC_IDLE;
      default: return ACC_BAD;
    endcase
  endfunction

endpackage

// File: rtl/dpram_port_dec.sv
module dpram_port_dec
  import dpram_sem_pkg::*;
(
  input  logic cs_n,
  input  logic sel_n,
  input  logic we_n,
  input  logic oe_n,
  output logic mem_wr,
  output logic mem_rd,
  output logic sem_wr,
  output logic sem_rd,
  output logic standby
);
  acc_e mode;
  assign mode    = acc_decode(cs_n, sel_n);
  assign mem_wr  = (mode == ACC_MEM) && !we_n;
  assign mem_rd  = (mode == ACC_MEM) && we_n && !oe_n;
  assign sem_wr  = (mode == ACC_SEM) && !we_n;
  assign sem_rd  = (mode == ACC_SEM) && we_n && !oe_n;
  assign standby = (mode == ACC_IDLE);
endmodule

// File: rtl/dpram_mem_array.sv
module dpram_mem_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [1:0]                    wr,
  input  logic [1:0]                    rd,
  input  logic [1:0][ADDR_W-1:0]        addr,
  input  logic [1:0][DATA_W-1:0]        wd,
  output logic [1:0][DATA_W-1:0]        q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Left write is issued last so it takes the location on a collision.
  always_ff @(posedge clk) begin
    if (wr[1]) mem[addr[1]] <= wd[1];
    if (wr[0]) mem[addr[0]] <= wd[0];
  end

  // Registered read: sees the contents from before this edge's writes.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (rd[p]) q[p] <= mem[addr[p]];
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_chk
    // R1
    mem_q_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rd[p] |=> $stable(q[p]));
  end
endmodule

// File: rtl/dpram_sem_bank.sv
module dpram_sem_bank #(
  parameter int SEM_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             wr,
  input  logic [1:0]             rd,
  input  logic [1:0][SEM_W-1:0]  idx,
  input  logic [1:0]             val,
  output logic [1:0][DATA_W-1:0] q
);
  localparam int N = 1 << SEM_W;

  logic [N-1:0] own_l, own_r, pend_l, pend_r;
  logic [N-1:0] n_own_l, n_own_r, n_pend_l, n_pend_r;
  logic [1:0]   rd_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic req_l, req_r, rel_l, rel_r;
    assign req_l = wr[0] && (idx[0] == SEM_W'(i)) && !val[0];
    assign rel_l = wr[0] && (idx[0] == SEM_W'(i)) &&  val[0];
    assign req_r = wr[1] && (idx[1] == SEM_W'(i)) && !val[1];
    assign rel_r = wr[1] && (idx[1] == SEM_W'(i)) &&  val[1];

    always_comb begin
      n_own_l[i]  = own_l[i];
      n_own_r[i]  = own_r[i];
      n_pend_l[i] = pend_l[i];
      n_pend_r[i] = pend_r[i];
      // Give-backs first; a queued claim from the other side takes over.
      if (rel_l) begin
        if (own_l[i]) begin
          n_own_l[i] = 1'b0;
          if (pend_r[i]) begin
            n_own_r[i]  = 1'b1;
            n_pend_r[i] = 1'b0;
          end
        end else begin
          n_pend_l[i] = 1'b0;
        end
      end
      if (rel_r) begin
        if (own_r[i]) begin
          n_own_r[i] = 1'b0;
          if (pend_l[i]) begin
            n_own_l[i]  = 1'b1;
            n_pend_l[i] = 1'b0;
          end
        end else begin
          n_pend_r[i] = 1'b0;
        end
      end
      // Claims next; left is evaluated first and so wins a tie.
      if (req_l) begin
        if (!n_own_l[i] && !n_own_r[i]) n_own_l[i] = 1'b1;
        else if (n_own_r[i])           n_pend_l[i] = 1'b1;
      end
      if (req_r) begin
        if (!n_own_r[i] && !n_own_l[i]) n_own_r[i] = 1'b1;
        else if (n_own_l[i])           n_pend_r[i] = 1'b1;
      end
    end

    // R8
    excl_owner_chk: assert property (@(posedge clk) disable iff (rst)
      !(own_l[i] && own_r[i]));
    // R8
    pend_needs_owner_chk: assert property (@(posedge clk) disable iff (rst)
      (!pend_r[i] || own_l[i]) && (!pend_l[i] || own_r[i]));
    // R10
    tie_left_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (req_l && req_r && !own_l[i] && !own_r[i]) |=> (own_l[i] && pend_r[i]));
    // R9
    handover_chk: assert property (@(posedge clk) disable iff (rst)
      (rel_l && own_l[i] && pend_r[i] && !wr[1]) |=> own_r[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_l  <= '0;
      own_r  <= '0;
      pend_l <= '0;
      pend_r <= '0;
      rd_q   <= '0;
      q      <= '0;
    end else begin
      own_l  <= n_own_l;
      own_r  <= n_own_r;
      pend_l <= n_pend_l;
      pend_r <= n_pend_r;
      rd_q   <= rd;
      if (rd[0] && !rd_q[0]) q[0] <= {DATA_W{~own_l[idx[0]]}};
      if (rd[1] && !rd_q[1]) q[1] <= {DATA_W{~own_r[idx[1]]}};
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd_chk
    // R11
    held_read_chk: assert property (@(posedge clk) disable iff (rst)
      (rd[p] && rd_q[p]) |=> $stable(q[p]));
  end
endmodule

// File: rtl/dpram_sem_top.sv
module dpram_sem_top #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int SEM_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_cs_n,
  input  logic              l_sel_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_standby,
  input  logic              r_cs_n,
  input  logic              r_sel_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_standby
);
  localparam int NP = 2;

  logic [NP-1:0]             cs_n_v, sel_n_v, we_n_v, oe_n_v;
  logic [NP-1:0][ADDR_W-1:0] addr_v;
  logic [NP-1:0][DATA_W-1:0] wd_v, mem_q, sem_q;
  logic [NP-1:0][SEM_W-1:0]  sem_idx;
  logic [NP-1:0]             sem_val;
  logic [NP-1:0]             mem_wr, mem_rd, sem_wr, sem_rd, stby;
  logic [NP-1:0]             src_sem, stby_q;

  // Index 0 is the left port, index 1 the right port.
  assign cs_n_v  = {r_cs_n,  l_cs_n};
  assign sel_n_v = {r_sel_n, l_sel_n};
  assign we_n_v  = {r_we_n,  l_we_n};
  assign oe_n_v  = {r_oe_n,  l_oe_n};
  assign addr_v  = {r_addr,  l_addr};
  assign wd_v    = {r_wdata, l_wdata};

  for (genvar p = 0; p < NP; p++) begin : g_port
    dpram_port_dec u_dec (
      .cs_n    (cs_n_v[p]),
      .sel_n   (sel_n_v[p]),
      .we_n    (we_n_v[p]),
      .oe_n    (oe_n_v[p]),
      .mem_wr  (mem_wr[p]),
      .mem_rd  (mem_rd[p]),
      .sem_wr  (sem_wr[p]),
      .sem_rd  (sem_rd[p]),
      .standby (stby[p])
    );
    assign sem_idx[p] = addr_v[p][SEM_W-1:0];
    assign sem_val[p] = wd_v[p][0];
  end

  dpram_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk  (clk),
    .rst  (rst),
    .wr   (mem_wr),
    .rd   (mem_rd),
    .addr (addr_v),
    .wd   (wd_v),
    .q    (mem_q)
  );

  dpram_sem_bank #(.SEM_W(SEM_W), .DATA_W(DATA_W)) u_sem (
    .clk (clk),
    .rst (rst),
    .wr  (sem_wr),
    .rd  (sem_rd),
    .idx (sem_idx),
    .val (sem_val),
    .q   (sem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sem <= '0;
      stby_q  <= '1;
    end else begin
      stby_q <= stby;
      for (int p = 0; p < NP; p++) begin
        if (mem_rd[p])      src_sem[p] <= 1'b0;
        else if (sem_rd[p]) src_sem[p] <= 1'b1;
      end
    end
  end

  assign l_rdata   = src_sem[0] ? sem_q[0] : mem_q[0];
  assign r_rdata   = src_sem[1] ? sem_q[1] : mem_q[1];
  assign l_standby = stby_q[0];
  assign r_standby = stby_q[1];

  // R5
  l_standby_set_chk: assert property (@(posedge clk) disable iff (rst)
    (l_cs_n && l_sel_n) |=> l_standby);
  // R5
  r_standby_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !r_cs_n |=> !r_standby);
  // R1
  l_rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (l_oe_n || !l_we_n) |=> $stable(l_rdata));
  // R1
  r_rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (r_oe_n || !r_we_n) |=> $stable(r_rdata));
endmodule

// File: tb/dpram_sem_top_tb_top.sv
`timescale 1ns/1ps
module dpram_sem_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_cs_n = 1, l_sel_n = 1, l_we_n = 1, l_oe_n = 1;
  logic r_cs_n = 1, r_sel_n = 1, r_we_n = 1, r_oe_n = 1;
  logic [11:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wdata = '0, r_wdata = '0;
  logic [7:0]  l_rdata, r_rdata;
  logic        l_standby, r_standby;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dpram_sem_top dut_i (
    .clk(clk), .rst(rst),
    .l_cs_n(l_cs_n), .l_sel_n(l_sel_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_standby(l_standby),
    .r_cs_n(r_cs_n), .r_sel_n(r_sel_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_standby(r_standby)
  );

  function automatic logic [7:0] pat_a(input int a);
    return 8'((a * 37 + (a >> 5)) & 255);
  endfunction
  function automatic logic [7:0] pat_b(input int a);
    return 8'(((a >> 4) ^ a ^ 8'hA5) & 255);
  endfunction
  function automatic logic [7:0] pat_c(input int a);
    return 8'((a * 11 + 3) & 255);
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_l();
    l_cs_n = 1; l_sel_n = 1; l_we_n = 1; l_oe_n = 1;
  endtask
  task automatic idle_r();
    r_cs_n = 1; r_sel_n = 1; r_we_n = 1; r_oe_n = 1;
  endtask

  task automatic drv(input int side, input logic cs, input logic sel, input logic we,
                     input logic oe, input int a, input logic [7:0] d);
    if (side == 0) begin
      l_cs_n = cs; l_sel_n = sel; l_we_n = we; l_oe_n = oe; l_addr = 12'(a); l_wdata = d;
    end else begin
      r_cs_n = cs; r_sel_n = sel; r_we_n = we; r_oe_n = oe; r_addr = 12'(a); r_wdata = d;
    end
  endtask

  task automatic mem_rd(input int side, input int a, input logic [7:0] exp, input string req);
    drv(side, 0, 1, 1, 0, a, 8'h00);
    step();
    check8(req, (side == 0) ? l_rdata : r_rdata, exp);
    if (side == 0) idle_l(); else idle_r();
  endtask

  task automatic sem_wr(input int side, input int i, input logic b);
    drv(side, 1, 0, 0, 1, i, {7'b0, b});
    step();
    if (side == 0) idle_l(); else idle_r();
  endtask

  task automatic sem_rd(input int side, input int i, input logic [7:0] exp, input string req);
    if (side == 0) idle_l(); else idle_r();
    step();
    drv(side, 1, 0, 1, 0, i, 8'h00);
    step();
    check8(req, (side == 0) ? l_rdata : r_rdata, exp);
    if (side == 0) idle_l(); else idle_r();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    check8("R12 l_rdata", l_rdata, 8'h00);
    check8("R12 r_rdata", r_rdata, 8'h00);
    check8("R12 l_standby", {7'b0, l_standby}, 8'h01);
    check8("R12 r_standby", {7'b0, r_standby}, 8'h01);

    // R1: left fills the array, right reads it all back
    for (int a = 0; a < 4096; a++) begin
      drv(0, 0, 1, 0, 1, a, pat_a(a));
      step();
    end
    idle_l();
    for (int a = 0; a < 4096; a++) mem_rd(1, a, pat_a(a), "R1 right read of left data");

    // R1: right overwrites, left reads back
    for (int a = 0; a < 4096; a++) begin
      drv(1, 0, 1, 0, 1, a, pat_b(a));
      step();
    end
    idle_r();
    for (int a = 0; a < 4096; a += 7) mem_rd(0, a, pat_b(a), "R1 left read of right data");

    // R2: left writes a while right reads the mirrored address in the same cycle
    for (int a = 0; a < 4096; a++) begin
      int m;
      m = a ^ 12'hFFF;
      drv(0, 0, 1, 0, 1, a, pat_c(a));
      drv(1, 0, 1, 1, 0, m, 8'h00);
      step();
      check8("R2 concurrent read", r_rdata, (a >= 2048) ? pat_c(m) : pat_b(m));
    end
    idle_l(); idle_r();

    // R1: read data holds through non-read cycles
    mem_rd(0, 100, pat_c(100), "R1 read");
    drv(0, 0, 1, 0, 1, 101, 8'h5A);
    step();
    check8("R1 hold during write", l_rdata, pat_c(100));
    idle_l();
    step();
    check8("R1 hold during idle", l_rdata, pat_c(100));
    mem_rd(0, 101, 8'h5A, "R1 write then read");

    // R3: same address written by both ports, left wins
    drv(0, 0, 1, 0, 1, 200, 8'h11);
    drv(1, 0, 1, 0, 1, 200, 8'h22);
    step();
    idle_l(); idle_r();
    mem_rd(1, 200, 8'h11, "R3 collision");

    // R4: read in the same cycle as a write returns the old byte
    drv(0, 0, 1, 0, 1, 300, 8'hC3);
    drv(1, 0, 1, 1, 0, 300, 8'h00);
    step();
    check8("R4 old data", r_rdata, pat_c(300));
    idle_l(); idle_r();
    mem_rd(1, 300, 8'hC3, "R4 new data after");

    // R5: standby indication and no access in standby
    step();
    check8("R5 standby high", {7'b0, l_standby}, 8'h01);
    drv(0, 1, 1, 0, 0, 400, 8'hEE);
    step();
    check8("R5 standby during ignored write", {7'b0, l_standby}, 8'h01);
    drv(0, 0, 1, 1, 1, 400, 8'h00);
    step();
    check8("R5 standby low when enabled", {7'b0, l_standby}, 8'h00);
    idle_l();
    mem_rd(0, 400, pat_c(400), "R5 standby write ignored");
    drv(0, 0, 0, 0, 1, 400, 8'h00);
    step();
    check8("R5 both-low standby", {7'b0, l_standby}, 8'h00);
    idle_l();
    mem_rd(0, 400, pat_c(400), "R5 both-low write ignored");
    sem_rd(0, 0, 8'hFF, "R5 both-low flag untouched");

    // Flag scenarios, swept over all eight flags
    for (int i = 0; i < 8; i++) begin
      int j;
      j = (i + 1) % 8;
      sem_rd(0, i, 8'hFF, "R12 flag free");
      sem_wr(0, i, 1'b0);
      sem_rd(0, i, 8'h00, "R7 owner reads zeros");
      sem_rd(1, i, 8'hFF, "R7 non-owner reads ones");
      sem_rd(0, j, 8'hFF, "R6 neighbour flag free");
      sem_wr(1, i, 1'b0);
      sem_rd(1, i, 8'hFF, "R8 claim queued");
      sem_rd(0, i, 8'h00, "R8 owner kept");
      // R11: right holds a read while left gives the flag back
      drv(1, 1, 0, 1, 0, i, 8'h00);
      step();
      check8("R11 first sample", r_rdata, 8'hFF);
      drv(0, 1, 0, 0, 1, i, 8'h01);
      step();
      idle_l();
      step();
      check8("R11 held read unchanged", r_rdata, 8'hFF);
      idle_r();
      step();
      drv(1, 1, 0, 1, 0, i, 8'h00);
      step();
      check8("R9 handover seen after pulse", r_rdata, 8'h00);
      idle_r();
      sem_rd(0, i, 8'hFF, "R9 old owner released");
      sem_wr(1, i, 1'b1);
      // R10: simultaneous claim of a free flag
      drv(0, 1, 0, 0, 1, i, 8'h00);
      drv(1, 1, 0, 0, 1, i, 8'h00);
      step();
      idle_l(); idle_r();
      sem_rd(0, i, 8'h00, "R10 left wins");
      sem_rd(1, i, 8'hFF, "R10 right queued");
      sem_wr(0, i, 1'b1);
      sem_rd(1, i, 8'h00, "R10 queued right takes over");
      sem_wr(1, i, 1'b1);
      // R8: non-owner writing 1 cancels its queued claim
      sem_wr(0, i, 1'b0);
      sem_wr(1, i, 1'b0);
      sem_wr(1, i, 1'b1);
      sem_wr(0, i, 1'b1);
      sem_rd(1, i, 8'hFF, "R8 cancelled claim not granted");
      sem_rd(0, i, 8'hFF, "R8 flag free after cancel");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule